// File: doc/BRIEF.md
# Light-Load Burst and Rectifier-Cutoff Manager

This block sits ahead of the gate sequencer of a phase-shifted full-bridge converter and decides, once per switching period, what that period may issue. At each period strobe it looks at the pulse width the loop is asking for, the minimum on-time setting, the cycle-limit flag, the sampled current-sense code and a light-load threshold code. From these it picks the pulse width for the coming period and whether the bridge gates run at all. Separately it decides whether the synchronous rectifiers may conduct.

A requested width below the minimum on-time is never passed through unless the cycle limit is in force. Instead the block starts a burst group: an even number of pulses at the minimum width, then a run of silent periods. The rectifiers are held off after every startup until two pulses have fully closed. They are also cut while the sensed current sits in the discontinuous region, and a hysteresis band stops them from chattering. Every decision is taken at a period boundary, so the sequencer never sees a partial pulse.

Top module: `llm_light_load_mgr`

## Requirements
- R1: While reset is held and in the cycle after it, `pulse_width` is 0, `gate_mask` is all zeros and `sr_en` is 0.
- R2: At a fresh decision with `req_width >= tmin_code`, the cycle after the strobe shows `pulse_width = req_width` and `gate_mask` all ones. A zero width always shows `gate_mask` all zeros.
- R3: Without `ilim_active`, no nonzero width below `tmin_code` is ever issued. A fresh decision with `req_width < tmin_code` starts a burst group whose pulse width is `tmin_code`.
- R4: A fresh decision taken with `ilim_active` high issues `req_width` even below `tmin_code` and does not start a burst. A burst pulse issued with `ilim_active` high has width min(`req_width`, `tmin_code`).
- R5: A burst group issues exactly BURST_PULSES pulses (an even count, default 2) whatever `req_width` does meanwhile. It then issues OFF_PERIODS periods (default 3) with width 0 and mask 0, and the next strobe is a fresh decision.
- R6: `pulse_width`, `gate_mask` and `sr_en` change only in the cycle right after a strobe. The one exception is the `sr_en` clear of R8.
- R7: `sr_en` can be 1 only after ARM_PULSES (2) periods with a nonzero width have each closed at a strobe, with `startup` low at that strobe, since `startup` was last high.
- R8: A cycle with `startup` high clears the pulse count, and `sr_en` is 0 from the next cycle on.
- R9: A strobe with `cs_code` below the effective threshold puts the block in discontinuous mode, and `sr_en` is 0 for that period.
- R10: Discontinuous mode ends only at a strobe with `cs_code >= threshold + HYST` (HYST default 4). Codes between the threshold and that level keep the current mode.
- R11: The effective threshold is `dcm_thr` clamped to [floor(5% of full scale), floor(30% of full scale)], which is [12, 76] for an 8-bit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_strobe | input | 1 | One-cycle pulse marking a switching-period boundary |
| startup | input | 1 | High during converter startup; clears rectifier arming |
| ilim_active | input | 1 | Cycle-by-cycle current limit is in force |
| req_width | input | W | Pulse width requested by the loop |
| tmin_code | input | W | Minimum on-time |
| cs_code | input | C | Sampled current-sense code |
| dcm_thr | input | C | Programmed discontinuous-mode threshold |
| gate_mask | output | NGATE | Bridge gate enables for the current period |
| pulse_width | output | W | Pulse width for the current period |
| sr_en | output | 1 | Synchronous rectifier enable |

## Verification
Rectifier arming and discontinuous-mode entry can land on the same strobe. The bench provokes this by starting a burst group right after startup and lowering the current-sense code below threshold at the very boundary where the second pulse closes. In that case `sr_en` must stay 0, and it must rise only at the next strobe, once the code is back above the exit level. The same scoreboard also judges a cycle-limit request that arrives in the middle of a burst group. That pulse must shrink to the requested width while the group's count and its silent periods go on unchanged.

// File: rtl/llm_pkg.sv
package llm_pkg;

  typedef enum logic [1:0] {
    PH_RUN       = 2'd0,
    PH_BURST_ON  = 2'd1,
    PH_BURST_OFF = 2'd2
  } burst_phase_t;

  // Fraction of the full-scale code of a 'bits'-wide value, rounded down.
  function automatic int unsigned pct_of_full(input int unsigned bits, input int unsigned pct);
    return (((32'd1 << bits) - 32'd1) * pct) / 32'd100;
  endfunction

endpackage

// File: rtl/llm_width_sel.sv
module llm_width_sel #(
  parameter int W            = 8,
  parameter int BURST_PULSES = 2,
  parameter int OFF_PERIODS  = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic         ilim_active,
  input  logic [W-1:0] req_width,
  input  logic [W-1:0] tmin_code,
  output logic [W-1:0] width_q,
  output logic         pulse_on
);
  import llm_pkg::*;

  localparam int CNT_MAX = (BURST_PULSES > OFF_PERIODS) ? BURST_PULSES : OFF_PERIODS;
  localparam int CW      = $clog2(CNT_MAX + 1);

  burst_phase_t  phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  width_d;
  logic          fresh;

  function automatic logic [W-1:0] min_w(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    width_d = width_q;
    fresh   = (phase_q == PH_RUN) ||
              ((phase_q == PH_BURST_OFF) && (cnt_q >= CW'(OFF_PERIODS)));
    if (strobe) begin
      if (fresh) begin
        if (ilim_active || (req_width >= tmin_code)) begin
          width_d = req_width;
          phase_d = PH_RUN;
          cnt_d   = '0;
        end else begin
          width_d = tmin_code;
          phase_d = PH_BURST_ON;
          cnt_d   = CW'(1);
        end
      end else if (phase_q == PH_BURST_ON) begin
        if (cnt_q < CW'(BURST_PULSES)) begin
          width_d = ilim_active ? min_w(req_width, tmin_code) : tmin_code;
          cnt_d   = cnt_q + CW'(1);
        end else begin
          width_d = '0;
          phase_d = PH_BURST_OFF;
          cnt_d   = CW'(1);
        end
      end else begin
        width_d = '0;
        cnt_d   = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
      cnt_q   <= '0;
      width_q <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      width_q <= width_d;
    end
  end

  assign pulse_on = |width_q;

  assert_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !ilim_active) |=> ((width_q == '0) || (width_q >= $past(tmin_code))));

  assert_even_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_BURST_OFF) && ($past(phase_q) == PH_BURST_ON)) |-> !$past(cnt_q[0]));

  assert_width_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(width_q));

endmodule

// File: rtl/llm_dcm_detect.sv
module llm_dcm_detect #(
  parameter int C    = 8,
  parameter int HYST = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [C-1:0] cs_code,
  input  logic [C-1:0] thr_code,
  output logic         dcm_q
);
  localparam logic [C-1:0] THR_LO = C'(llm_pkg::pct_of_full(C, 5));
  localparam logic [C-1:0] THR_HI = C'(llm_pkg::pct_of_full(C, 30));

  function automatic logic [C-1:0] clamp_thr(input logic [C-1:0] t);
    if (t < THR_LO)      return THR_LO;
    else if (t > THR_HI) return THR_HI;
    else                 return t;
  endfunction

  logic [C-1:0] thr_eff;
  logic [C:0]   exit_lvl;
  logic         dcm_d;

  assign thr_eff  = clamp_thr(thr_code);
  assign exit_lvl = {1'b0, thr_eff} + (C+1)'(HYST);

  always_comb begin
    dcm_d = dcm_q;
    if (strobe) begin
      if (dcm_q) dcm_d = ({1'b0, cs_code} < exit_lvl);
      else       dcm_d = (cs_code < thr_eff);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dcm_q <= 1'b0;
    else        dcm_q <= dcm_d;
  end

  always_comb begin
    if (rst_n) begin
      assert_thr_range_R11: assert ((thr_eff >= THR_LO) && (thr_eff <= THR_HI));
    end
  end

  assert_hyst_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && dcm_q && ({1'b0, cs_code} < exit_lvl)) |=> dcm_q);

endmodule

// File: rtl/llm_sr_arm.sv
module llm_sr_arm #(
  parameter int ARM_PULSES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic startup,
  input  logic pulse_on,
  output logic armed
);
  localparam int AW = $clog2(ARM_PULSES + 1);

  logic [AW-1:0] done_q;

  always_ff @(posedge clk) begin
    if (!rst_n || startup) begin
      done_q <= '0;
    end else if (strobe && pulse_on && (done_q < AW'(ARM_PULSES))) begin
      done_q <= done_q + AW'(1);
    end
  end

  assign armed = (done_q == AW'(ARM_PULSES));

  assert_arm_needs_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> ($past(strobe) && $past(pulse_on) && !$past(startup)));

endmodule

// File: rtl/llm_light_load_mgr.sv
module llm_light_load_mgr #(
  parameter int W            = 8,
  parameter int C            = 8,
  parameter int NGATE        = 4,
  parameter int BURST_PULSES = 2,
  parameter int OFF_PERIODS  = 3,
  parameter int HYST         = 4,
  parameter int ARM_PULSES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_strobe,
  input  logic             startup,
  input  logic             ilim_active,
  input  logic [W-1:0]     req_width,
  input  logic [W-1:0]     tmin_code,
  input  logic [C-1:0]     cs_code,
  input  logic [C-1:0]     dcm_thr,
  output logic [NGATE-1:0] gate_mask,
  output logic [W-1:0]     pulse_width,
  output logic             sr_en
);
  logic pulse_on;
  logic dcm_active;
  logic armed;

  llm_width_sel #(
    .W(W), .BURST_PULSES(BURST_PULSES), .OFF_PERIODS(OFF_PERIODS)
  ) u_width_sel (
    .clk(clk), .rst_n(rst_n), .strobe(period_strobe), .ilim_active(ilim_active),
    .req_width(req_width), .tmin_code(tmin_code),
    .width_q(pulse_width), .pulse_on(pulse_on)
  );

  llm_dcm_detect #(.C(C), .HYST(HYST)) u_dcm (
    .clk(clk), .rst_n(rst_n), .strobe(period_strobe),
    .cs_code(cs_code), .thr_code(dcm_thr), .dcm_q(dcm_active)
  );

  llm_sr_arm #(.ARM_PULSES(ARM_PULSES)) u_arm (
    .clk(clk), .rst_n(rst_n), .strobe(period_strobe), .startup(startup),
    .pulse_on(pulse_on), .armed(armed)
  );

  for (genvar g = 0; g < NGATE; g++) begin : g_mask
    assign gate_mask[g] = pulse_on;
  end

  assign sr_en = armed & ~dcm_active;

  assert_startup_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    startup |=> !sr_en);

  assert_sr_rise_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_en) |-> $past(period_strobe));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !period_strobe |=> $stable(gate_mask));

endmodule

// File: tb/llm_light_load_mgr_bench.sv
module llm_light_load_mgr_bench;
  localparam int W = 8, C = 8, NG = 4, BP = 2, OFFP = 3, HY = 4, ARM = 2;
  localparam int FULL = (1 << C) - 1;
  localparam int TLO = (FULL * 5) / 100;
  localparam int THI = (FULL * 30) / 100;

  logic clk = 0, rst_n = 0, strobe = 0, startup = 0, ilim = 0;
  logic [W-1:0] req = '0, tmin = '0;
  logic [C-1:0] cs = '0, thr = '0;
  logic [NG-1:0] gate_mask;
  logic [W-1:0] pulse_width;
  logic sr_en;

  always #10 clk = ~clk;

  llm_light_load_mgr u_llm_light_load_mgr (
    .clk(clk), .rst_n(rst_n), .period_strobe(strobe), .startup(startup),
    .ilim_active(ilim), .req_width(req), .tmin_code(tmin), .cs_code(cs),
    .dcm_thr(thr), .gate_mask(gate_mask), .pulse_width(pulse_width), .sr_en(sr_en)
  );

  typedef struct {
    int    w;
    int    m;
    int    sr;
    string wtag;
    string stag;
  } exp_t;

  exp_t sb[$];
  int total = 0, failed = 0;

  // bench-side model state
  int  m_phase = 0;  // 0 run, 1 burst pulses, 2 burst silence
  int  m_cnt = 0, m_w = 0, m_done = 0;
  bit  m_dcm = 0;
  int  m_sr = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic period(input int r, input int t, input int c, input int th,
                        input bit il, input bit su, input string wtag, input string stag);
    exp_t e;
    int prev_on, te;
    @(negedge clk);
    req = W'(r); tmin = W'(t); cs = C'(c); thr = C'(th); ilim = il; startup = su;
    prev_on = (m_w != 0);
    if (m_phase == 0 || (m_phase == 2 && m_cnt >= OFFP)) begin
      if (il || r >= t) begin m_w = r; m_phase = 0; m_cnt = 0; end
      else begin m_w = t; m_phase = 1; m_cnt = 1; end
    end else if (m_phase == 1) begin
      if (m_cnt < BP) begin m_w = il ? ((r < t) ? r : t) : t; m_cnt++; end
      else begin m_w = 0; m_phase = 2; m_cnt = 1; end
    end else begin
      m_w = 0; m_cnt++;
    end
    if (su) m_done = 0;
    else if (prev_on != 0 && m_done < ARM) m_done++;
    te = (th < TLO) ? TLO : ((th > THI) ? THI : th);
    if (m_dcm) m_dcm = (c < te + HY);
    else       m_dcm = (c < te);
    m_sr = (m_done == ARM && !m_dcm) ? 1 : 0;
    e.w = m_w; e.m = (m_w != 0) ? ((1 << NG) - 1) : 0; e.sr = m_sr;
    e.wtag = wtag; e.stag = stag;
    sb.push_back(e);
    strobe = 1;
    @(negedge clk);
    strobe = 0;
    repeat (3) @(negedge clk);
    chk("R6 width held", int'(pulse_width), e.w);
    chk("R6 mask held", int'(gate_mask), e.m);
    chk("R6 sr held", int'(sr_en), e.sr);
  endtask

  // monitor: pops one expected item per strobe, compares right after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (strobe) begin
        @(negedge clk);
        if (sb.size() == 0) begin
          chk("scoreboard empty", 1, 0);
        end else begin
          e = sb.pop_front();
          chk({e.wtag, " width"}, int'(pulse_width), e.w);
          chk({e.wtag, " mask"}, int'(gate_mask), e.m);
          chk({e.stag, " sr_en"}, int'(sr_en), e.sr);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 width in reset", int'(pulse_width), 0);
    chk("R1 mask in reset", int'(gate_mask), 0);
    chk("R1 sr in reset", int'(sr_en), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 width after reset", int'(pulse_width), 0);
    chk("R1 sr after reset", int'(sr_en), 0);

    // startup and arming
    period(100, 20, 200, 40, 0, 1, "R2", "R8");
    period(100, 20, 200, 40, 0, 0, "R2", "R7");
    period(100, 20, 200, 40, 0, 0, "R2", "R7");
    // discontinuous mode with hysteresis
    period(60, 20, 30, 40, 0, 0, "R2", "R9");
    period(60, 20, 42, 40, 0, 0, "R2", "R10");
    period(60, 20, 44, 40, 0, 0, "R2", "R10");
    // threshold clamp, low and high ends
    period(60, 20, 10, 2, 0, 0, "R2", "R11");
    period(60, 20, 15, 2, 0, 0, "R2", "R11");
    period(60, 20, 16, 2, 0, 0, "R2", "R11");
    period(60, 20, 75, 200, 0, 0, "R2", "R11");
    period(60, 20, 80, 200, 0, 0, "R2", "R11");
    // burst group, request rising mid-group
    period(5, 20, 200, 40, 0, 0, "R3", "R9");
    period(100, 20, 200, 40, 0, 0, "R5", "R9");
    period(100, 20, 200, 40, 0, 0, "R5", "R9");
    period(100, 20, 200, 40, 0, 0, "R5", "R9");
    period(100, 20, 200, 40, 0, 0, "R5", "R9");
    period(100, 20, 200, 40, 0, 0, "R5", "R9");
    // cycle limit inside a burst group and at a fresh decision
    period(5, 20, 200, 40, 0, 0, "R3", "R9");
    period(5, 20, 200, 40, 1, 0, "R4", "R9");
    period(5, 20, 200, 40, 0, 0, "R5", "R9");
    period(5, 20, 200, 40, 0, 0, "R5", "R9");
    period(5, 20, 200, 40, 0, 0, "R5", "R9");
    period(7, 20, 200, 40, 1, 0, "R4", "R9");
    // burst at startup; arming and DCM entry on the same strobe
    period(5, 20, 200, 40, 0, 1, "R3", "R8");
    period(5, 20, 200, 40, 0, 0, "R5", "R7");
    period(5, 20, 30, 40, 0, 0, "R5", "R9");
    period(5, 20, 200, 40, 0, 0, "R5", "R10");
    period(5, 20, 200, 40, 0, 0, "R5", "R10");
    period(100, 20, 200, 40, 0, 0, "R2", "R7");
    // varied patterns
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      period(int'(lfsr[7:0]), 16 + int'(lfsr[11:8]), int'(lfsr[15:8]), int'(lfsr[6:0]),
             lfsr[13] & lfsr[14], (i == 20), "R3", "R10");
    end
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule